// File: doc/BRIEF.md
# Octant Coil Drive Code Generator

This block turns a 10-bit pointer angle into a pair of signed drive codes for the two coils of an air-core gauge. One code goes to the sine coil and one to the cosine coil, and each is meant to feed a DAC. The angle is split into eight 45° octants with 128 steps in each. That gives 1024 steps per turn, each about 0.35°.

In every octant one coil is pinned at full scale and the other ramps. The ramp magnitude follows a tangent-shaped curve, so the pointer moves at a nearly even angular rate. The sign of each coil follows a fixed pattern around the circle.

A new angle is accepted when a valid strobe is high. The angle is held between strobes. The drive codes are registered. An enable input forces both codes to zero, and when enable returns, the codes come back for the held angle without a new strobe.

Top module: `octant_coil_drive`

## Requirements
- R1: While `rst` is high at a clock edge, both codes become 0 at that edge and the held angle becomes 0. The first enabled edge after reset with no strobe gives sine 0 and cosine +511.
- R2: Angle bits [9:7] are the octant number (0..7) and bits [6:0] are the fraction f (0..127) within that octant.
- R3: The pinned coil is at ±511 with this assignment. Cosine is pinned in octants 0, 3, 4 and 7. Sine is pinned in octants 1, 2, 5 and 6.
- R4: The ramping coil has magnitude round(511·tan(k·π/512)). Here k = f in octants 0, 2, 4 and 6, and k = 128 − f in octants 1, 3, 5 and 7.
- R5: The sine code is negative (or zero) in octants 4 to 7 and positive elsewhere. The cosine code is negative (or zero) in octants 2 to 5 and positive elsewhere.
- R6: At the octant boundaries the (sine, cosine) pairs are as follows. Code 0 gives (0, 511). Code 128 gives (511, 511). Code 256 gives (511, 0). Code 384 gives (511, −511). Code 512 gives (0, −511). Code 640 gives (−511, −511). Code 768 gives (−511, 0). Code 896 gives (−511, 511).
- R7: When `angle_vld` and `drive_en` are high at a clock edge, the codes for `angle_in` appear at that same edge, which is one cycle of latency.
- R8: With `angle_vld` low, `angle_in` is ignored. The codes keep the value of the last accepted angle.
- R9: When `drive_en` is low at an edge, both codes become 0 at that edge. At the first enabled edge afterwards, the codes of the held angle return even if no strobe comes.
- R10: The codes are 10-bit two's complement and never take the value −512.
- R11: Code 1023 gives sine −3 and cosine +511.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| angle_vld | input | 1 | Strobe that accepts `angle_in` |
| angle_in | input | 10 | Angle code, octant in [9:7] and fraction in [6:0] |
| drive_en | input | 1 | Output enable; when low, both codes are forced to zero |
| sin_code | output | 10 | Signed sine coil drive code |
| cos_code | output | 10 | Signed cosine coil drive code |

## Verification
The assertions assume that `angle_vld` and `drive_en` are always driven to known values and that reset is held for at least one edge before either is used. The hold and stability properties also assume that `angle_in` changes only around a strobe that matters. The bench changes every input only on the falling clock edge and holds reset for several edges at the start. It sweeps all 1024 codes and then sends pseudo-random strobes, angles and enable gaps. This keeps the stimulus inside those assumptions while still changing `angle_in` freely while the strobe is low.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

  // Octant count is fixed by the geometry: eight 45 degree sectors.
  localparam int OCT_W = 3;
  localparam real PI_R = 3.141592653589793;

  // Decoded per-octant plan.
  typedef struct packed {
    logic sin_pinned;  // sine coil held at full scale
    logic ramp_up;     // ramp magnitude grows with the fraction
    logic sin_neg;     // sine code negated
    logic cos_neg;     // cosine code negated
  } oct_plan_t;

  // Rounded full*tan(idx*pi/(4*steps)).
  function automatic int tan_code(input int idx, input int steps, input int full);
    real r;
    r = real'(full) * $tan(real'(idx) * PI_R / (4.0 * real'(steps)));
    return $rtoi(r + 0.5);
  endfunction

endpackage

// File: rtl/ocd_angle_hold.sv
module ocd_angle_hold #(
  parameter int ANG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ANG_W-1:0] ang_in,
  output logic [ANG_W-1:0] ang_eff
);

  logic [ANG_W-1:0] ang_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ang_q <= '0;
    end else if (load) begin
      ang_q <= ang_in;
    end
  end

  // The fresh angle is used in the cycle of the strobe, so output latency is one edge.
  assign ang_eff = load ? ang_in : ang_q;

  // R8: without a strobe the held angle does not move.
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ang_q));

endmodule

// File: rtl/ocd_octant_map.sv
module ocd_octant_map
  import ocd_pkg::*;
#(
  parameter int FRAC_W = 7
) (
  input  logic [OCT_W-1:0]  octant,
  input  logic [FRAC_W-1:0] frac,
  output oct_plan_t         plan,
  output logic [FRAC_W:0]   rom_addr
);

  localparam logic [FRAC_W:0] SPAN = {1'b1, {FRAC_W{1'b0}}};

  always_comb begin
    plan.sin_pinned = octant[0] ^ octant[1];
    plan.ramp_up    = ~octant[0];
    plan.sin_neg    = octant[2];
    plan.cos_neg    = octant[2] ^ octant[1];
    if (plan.ramp_up) begin
      rom_addr = {1'b0, frac};
    end else begin
      rom_addr = SPAN - {1'b0, frac};
    end
  end

endmodule

// File: rtl/ocd_tan_rom.sv
module ocd_tan_rom
  import ocd_pkg::*;
#(
  parameter int FRAC_W = 7,
  parameter int MAG_W  = 9
) (
  input  logic [FRAC_W:0]  addr,
  output logic [MAG_W-1:0] mag
);

  localparam int STEPS = 2 ** FRAC_W;
  localparam int DEPTH = STEPS + 1;
  localparam int FULL  = 2 ** MAG_W - 1;

  logic [MAG_W-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rom[i] = MAG_W'(tan_code(i, STEPS, FULL));
    end
  end

  // Asynchronous read keeps the angle-to-code path inside one register stage.
  assign mag = rom[addr];

endmodule

// File: rtl/ocd_drive_reg.sv
module ocd_drive_reg
  import ocd_pkg::*;
#(
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  oct_plan_t        plan,
  input  logic [OUT_W-2:0] ramp_mag,
  output logic [OUT_W-1:0] sin_q,
  output logic [OUT_W-1:0] cos_q
);

  localparam logic [OUT_W-1:0] FULL_P = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] FULL_N = {1'b1, {(OUT_W-2){1'b0}}, 1'b1};
  localparam logic [OUT_W-1:0] MIN_V  = {1'b1, {(OUT_W-1){1'b0}}};

  logic [OUT_W-1:0] ramp_ext, sin_mag, cos_mag, sin_nxt, cos_nxt;

  always_comb begin
    ramp_ext = {1'b0, ramp_mag};
    sin_mag  = plan.sin_pinned ? FULL_P : ramp_ext;
    cos_mag  = plan.sin_pinned ? ramp_ext : FULL_P;
    sin_nxt  = plan.sin_neg ? (~sin_mag + OUT_W'(1)) : sin_mag;
    cos_nxt  = plan.cos_neg ? (~cos_mag + OUT_W'(1)) : cos_mag;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sin_q <= '0;
      cos_q <= '0;
    end else begin
      sin_q <= sin_nxt;
      cos_q <= cos_nxt;
    end
  end

  // R1: reset clears both codes.
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (sin_q == '0 && cos_q == '0));

  // R9: a disabled edge forces zero.
  a_r9_disable_zero: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sin_q == '0 && cos_q == '0));

  // R3: while enabled, at least one coil sits at full scale.
  a_r3_one_full: assert property (@(posedge clk) disable iff (rst)
    en |=> (sin_q == FULL_P || sin_q == FULL_N || cos_q == FULL_P || cos_q == FULL_N));

  // R10: the most negative code never appears.
  a_r10_no_min: assert property (@(posedge clk) disable iff (rst)
    (sin_q != MIN_V) && (cos_q != MIN_V));

endmodule

// File: rtl/octant_coil_drive.sv
module octant_coil_drive
  import ocd_pkg::*;
#(
  parameter int FRAC_W = 7,
  parameter int OUT_W  = 10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           angle_vld,
  input  logic [OCT_W+FRAC_W-1:0]        angle_in,
  input  logic                           drive_en,
  output logic signed [OUT_W-1:0]        sin_code,
  output logic signed [OUT_W-1:0]        cos_code
);

  localparam int ANG_W = OCT_W + FRAC_W;
  localparam int MAG_W = OUT_W - 1;
  localparam logic [FRAC_W:0] SPAN = {1'b1, {FRAC_W{1'b0}}};

  logic [ANG_W-1:0] ang_eff;
  oct_plan_t        plan;
  logic [FRAC_W:0]  rom_addr;
  logic [MAG_W-1:0] ramp_mag;
  logic [OUT_W-1:0] sin_q, cos_q;

  ocd_angle_hold #(.ANG_W(ANG_W)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load   (angle_vld),
    .ang_in (angle_in),
    .ang_eff(ang_eff)
  );

  ocd_octant_map #(.FRAC_W(FRAC_W)) u_map (
    .octant  (ang_eff[ANG_W-1 -: OCT_W]),
    .frac    (ang_eff[FRAC_W-1:0]),
    .plan    (plan),
    .rom_addr(rom_addr)
  );

  ocd_tan_rom #(.FRAC_W(FRAC_W), .MAG_W(MAG_W)) u_rom (
    .addr(rom_addr),
    .mag (ramp_mag)
  );

  ocd_drive_reg #(.OUT_W(OUT_W)) u_drive (
    .clk     (clk),
    .rst     (rst),
    .en      (drive_en),
    .plan    (plan),
    .ramp_mag(ramp_mag),
    .sin_q   (sin_q),
    .cos_q   (cos_q)
  );

  assign sin_code = sin_q;
  assign cos_code = cos_q;

  // R4: the ramp index never runs past the 45 degree point.
  a_r4_addr_bound: assert property (@(posedge clk) disable iff (rst)
    rom_addr <= SPAN);

  // R8: with enable steady and no strobe, the codes hold.
  a_r8_codes_hold: assert property (@(posedge clk) disable iff (rst)
    (drive_en && !angle_vld && $past(drive_en) && !$past(rst))
      |=> ($stable(sin_code) && $stable(cos_code)));

endmodule

// File: tb/octant_coil_drive_tb.sv
module octant_coil_drive_tb_top;

  localparam real PI_B = 3.141592653589793;
  localparam int  WD_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       angle_vld = 1'b0;
  logic [9:0] angle_in = '0;
  logic       drive_en = 1'b0;
  logic signed [9:0] sin_code, cos_code;

  int checks = 0;
  int errors = 0;
  bit checking = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  int exp_s = 0, exp_c = 0, held = 0;

  always #10 clk = ~clk;  // 50 MHz

  octant_coil_drive dut_i (
    .clk(clk), .rst(rst), .angle_vld(angle_vld), .angle_in(angle_in),
    .drive_en(drive_en), .sin_code(sin_code), .cos_code(cos_code)
  );

  function automatic int ramp(input int k);
    return $rtoi(511.0 * $tan(real'(k) * PI_B / 512.0) + 0.5);
  endfunction

  function automatic void ref_codes(input int code, output int s, output int c);
    int oct, f, r;
    oct = code / 128;
    f   = code % 128;
    r   = (oct % 2 == 0) ? ramp(f) : ramp(128 - f);
    case (oct)
      0: begin s =  r;   c =  511; end
      1: begin s =  511; c =  r;   end
      2: begin s =  511; c = -r;   end
      3: begin s =  r;   c = -511; end
      4: begin s = -r;   c = -511; end
      5: begin s = -511; c = -r;   end
      6: begin s = -511; c =  r;   end
      default: begin s = -r; c = 511; end
    endcase
  endfunction

  // Reference model updated at each rising edge from the stable inputs.
  always @(posedge clk) begin
    int s, c, h;
    if (rst) begin
      held  <= 0;
      exp_s <= 0;
      exp_c <= 0;
    end else begin
      h = angle_vld ? int'(angle_in) : held;
      held <= h;
      if (drive_en) begin
        ref_codes(h, s, c);
        exp_s <= s;
        exp_c <= c;
      end else begin
        exp_s <= 0;
        exp_c <= 0;
      end
    end
  end

  // Cycle compare at the falling edge.
  always @(negedge clk) begin
    if (checking) begin
      checks++;
      if (int'(sin_code) != exp_s || int'(cos_code) != exp_c) begin
        errors++;
        $display("FAIL %s: sin/cos actual %0d/%0d expected %0d/%0d",
                 cur_req, sin_code, cos_code, exp_s, exp_c);
      end
      checks++;
      if (sin_code == -10'sd512 || cos_code == -10'sd512) begin
        errors++;
        $display("FAIL R10: actual %0d/%0d expected no -512", sin_code, cos_code);
      end
    end
  end

  task automatic drive(input bit v, input int a, input bit e);
    @(negedge clk);
    angle_vld = v;
    angle_in  = 10'(a);
    drive_en  = e;
  endtask

  task automatic lit(input string req, input int code, input int se, input int ce);
    drive(1'b1, code, 1'b1);
    @(negedge clk);
    checks++;
    if (int'(sin_code) != se || int'(cos_code) != ce) begin
      errors++;
      $display("FAIL %s code %0d: actual %0d/%0d expected %0d/%0d",
               req, code, sin_code, cos_code, se, ce);
    end
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset with noisy inputs.
    cur_req = "R1";
    checking = 1'b1;
    drive(1'b1, 700, 1'b1);
    drive(1'b1, 300, 1'b1);
    drive(1'b0, 5, 1'b1);
    drive(1'b0, 900, 1'b1);
    rst = 1'b0;
    drive(1'b0, 900, 1'b1);
    drive(1'b0, 900, 1'b1);

    // R2 R3 R4 R5: full sweep, one code per cycle.
    cur_req = "R2 R3 R4 R5";
    for (int i = 0; i < 1024; i++) drive(1'b1, i, 1'b1);

    // R6 R11: boundary codes against literal values.
    cur_req = "R6";
    lit("R6", 0,    0,    511);
    lit("R6", 128,  511,  511);
    lit("R6", 256,  511,  0);
    lit("R6", 384,  511, -511);
    lit("R6", 512,  0,   -511);
    lit("R6", 640, -511, -511);
    lit("R6", 768, -511,  0);
    lit("R6", 896, -511,  511);
    cur_req = "R11";
    lit("R11", 1023, -3, 511);

    // R7 R8: single strobes, angle_in wanders while the strobe is low.
    cur_req = "R7 R8";
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, 37 + i * 123, 1'b1);
      for (int j = 0; j < 3; j++) drive(1'b0, 1000 - i * 97 - j * 11, 1'b1);
    end

    // R9: disable with strobes, then re-enable with no strobe.
    cur_req = "R9";
    drive(1'b1, 450, 1'b1);
    drive(1'b0, 450, 1'b0);
    drive(1'b1, 200, 1'b0);
    drive(1'b0, 999, 1'b0);
    drive(1'b0, 999, 1'b1);
    drive(1'b0, 999, 1'b1);
    drive(1'b0, 999, 1'b0);
    drive(1'b0, 999, 1'b1);

    // Mixed pseudo-random traffic.
    cur_req = "R2 R7 R8 R9";
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive(lfsr[0], int'(lfsr[15:6]), lfsr[3:1] != 3'b000);
    end
    drive(1'b0, 0, 1'b1);
    drive(1'b0, 0, 1'b1);
    checking = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule